// File: doc/BRIEF.md
# SPI Flash User-Mode Controller

This block attaches up to five serial flash devices to a processor through two memory-mapped paths. A 32-bit register path holds a global configuration word, an extended-address word, a timing word and one control word per attached device. A flash window path carries byte, half-word, three-byte and word loads and stores. When a device is in its software-driven (user) mode, each of these accesses becomes a run of SPI byte exchanges on a shared clock and data pair.

Each device has its own active-low select line. The select line comes straight from a stop flag in that device's control word, so software frames a flash command by clearing the flag, moving bytes through the window, and then setting the flag again. The window is split into one fixed region per device. Loads and stores stall on a single-cycle ready pulse until every byte has been shifted.

Top module: `spi_flash_user_ctrl`

## Requirements
- R1: After a synchronous reset, every select line is high, every control word reads 0x00000004, and the configuration word reads 0.
- R2: The register path uses a word index. Index 0 is configuration, 1 is extended address, 4+n is the control word of device n for n below NUM_CS, and 37 (byte offset 0x94) is timing. These words read back what was written. Any other index reads 0 and ignores writes. Read data and ack appear one cycle after the request.
- R3: spi_cs_n[n] equals bit 2 of control word n and changes in the cycle after that word is written.
- R4: Bits [1:0] of a control word select the access mode. Value 3 is user mode. Values 0, 1 and 2 are non-user modes, and the stored field reads back unchanged.
- R5: A user-mode window load of win_len+1 bytes performs that many exchanges with 0x00 driven out. Received byte i lands in win_rdata[8i+7:8i].
- R6: A user-mode window store of win_len+1 bytes sends win_wdata least significant byte first, one exchange per byte, with only the addressed device selected.
- R7: A store to device n is dropped, with no SPI activity, unless configuration bit 16+n is set.
- R8: A load from a device that is not in user mode returns 0xFFFFFFFF with no SPI activity. A store to such a device is dropped.
- R9: Window decode gives device 0 the range [0, 64 MiB) and gives device k≥1 the 32 MiB range starting at 64 MiB+(k-1)·32 MiB. An address beyond the last present device reads 0 and drops stores.
- R10: The SPI clock idles low and has a period of CLK_DIV clocks (40 ns at the defaults). Data is shifted out most significant bit first and sampled on the rising edge.
- R11: win_ready is a one-cycle pulse that ends each window access. The mode and write permission are taken from the register values held at acceptance, so a register write in the acceptance cycle only affects later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access strobe, one cycle |
| reg_we | input | 1 | Register write when 1 |
| reg_addr | input | RAW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_ack | output | 1 | Register access done |
| win_req | input | 1 | Window access request, held until win_ready |
| win_we | input | 1 | Window store when 1 |
| win_addr | input | WIN_AW | Window byte address |
| win_len | input | 2 | Access length minus one |
| win_wdata | input | 32 | Window store data |
| win_rdata | output | 32 | Window load data |
| win_ready | output | 1 | Window access complete pulse |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | NUM_CS | Per-device select, active low |

## Verification
A register write that changes a control word can arrive in the same cycle as the acceptance of a window access aimed at that device. The bench provokes this by driving a control-word write that moves device 0 out of user mode on the same falling edge that it raises a window load to device 0. The load must still run as a user-mode exchange and return slave data, because acceptance uses the old mode. The next load must return all ones. Select-line timing and transmitted bytes are judged through a loopback slave model that logs every byte together with the select pattern present during it.

// File: rtl/spi_ucp_pkg.sv
package spi_ucp_pkg;
  typedef enum logic [1:0] {
    MODE_RD   = 2'd0,
    MODE_FRD  = 2'd1,
    MODE_WR   = 2'd2,
    MODE_USER = 2'd3
  } flash_mode_e;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_XFER = 1'b1
  } acc_state_e;

  localparam int W_CFG    = 0;
  localparam int W_EXT    = 1;
  localparam int W_CTRL0  = 4;
  localparam int W_TIM    = 37;
  localparam int STOP_BIT = 2;
  localparam int WEN_BASE = 16;
endpackage

// File: rtl/spi_ucp_regs.sv
module spi_ucp_regs import spi_ucp_pkg::*; #(
  parameter int NUM_CS = 5,
  parameter int RAW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [RAW-1:0]    addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ack,
  output logic [NUM_CS-1:0] cs_n,
  output logic [NUM_CS-1:0] user_mode,
  output logic [NUM_CS-1:0] wr_en
);
  logic [31:0] cfg_q, ext_q, tim_q;
  logic [31:0] ctrl_q [NUM_CS];
  logic        ctrl_hit, impl;
  logic [31:0] rd_val;

  assign ctrl_hit = (addr >= RAW'(W_CTRL0)) && (addr < RAW'(W_CTRL0 + NUM_CS));
  assign impl = (addr == RAW'(W_CFG)) || (addr == RAW'(W_EXT)) ||
                (addr == RAW'(W_TIM)) || ctrl_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ext_q <= '0;
      tim_q <= '0;
    end else if (req && we) begin
      if (addr == RAW'(W_CFG)) cfg_q <= wdata;
      if (addr == RAW'(W_EXT)) ext_q <= wdata;
      if (addr == RAW'(W_TIM)) tim_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic [31:0] c_q;
    always_ff @(posedge clk) begin
      if (rst) c_q <= 32'(1 << STOP_BIT);
      else if (req && we && addr == RAW'(W_CTRL0 + g)) c_q <= wdata;
    end
    assign ctrl_q[g]    = c_q;
    assign cs_n[g]      = c_q[STOP_BIT];
    assign user_mode[g] = (c_q[1:0] == MODE_USER);
    assign wr_en[g]     = cfg_q[WEN_BASE + g];
  end

  always_comb begin
    rd_val = '0;
    if (addr == RAW'(W_CFG)) rd_val = cfg_q;
    if (addr == RAW'(W_EXT)) rd_val = ext_q;
    if (addr == RAW'(W_TIM)) rd_val = tim_q;
    for (int g = 0; g < NUM_CS; g++)
      if (addr == RAW'(W_CTRL0 + g)) rd_val = ctrl_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      ack   <= 1'b0;
    end else begin
      ack   <= req;
      rdata <= (req && impl) ? rd_val : '0;
    end
  end

  // R3: select lines move only after a register write
  a_r3_cs_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(req && we) |-> $stable(cs_n));
  // R2: unimplemented index reads zero
  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (ack && !$past(impl)) |-> (rdata == 32'd0));
endmodule

// File: rtl/spi_ucp_decode.sv
module spi_ucp_decode #(
  parameter int NUM_CS = 5,
  parameter int WIN_AW = 28,
  parameter int CS0_LG = 26,
  parameter int CSX_LG = 25,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [WIN_AW-1:0] addr,
  output logic              hit,
  output logic [CSW-1:0]    idx
);
  localparam logic [WIN_AW-1:0] CS0_BYTES = WIN_AW'(1) << CS0_LG;
  logic [WIN_AW-1:0] off;
  logic [31:0]       idx_full;

  always_comb begin
    off = addr - CS0_BYTES;
    if (addr < CS0_BYTES) idx_full = 32'd0;
    else                  idx_full = 32'(off >> CSX_LG) + 32'd1;
    hit = (idx_full < 32'(NUM_CS));
    idx = idx_full[CSW-1:0];
  end
endmodule

// File: rtl/spi_ucp_shifter.sv
module spi_ucp_shifter #(
  parameter int CLK_DIV = 4,
  localparam int HALF   = CLK_DIV / 2,
  localparam int DW     = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  assign mosi = sh_q[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; sck <= 1'b0;
      div_q <= '0; bit_q <= '0; sh_q <= '0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh_q <= tx_byte; busy <= 1'b1; div_q <= '0; bit_q <= '0; sck <= 1'b0;
      end else if (busy) begin
        if (div_q == DW'(HALF - 1)) begin
          div_q <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_q == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  // R10: clock idles low, data held across the rising edge
  a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  a_r10_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));
  a_r10_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/spi_flash_user_ctrl.sv
module spi_flash_user_ctrl import spi_ucp_pkg::*; #(
  parameter int NUM_CS  = 5,
  parameter int RAW     = 6,
  parameter int WIN_AW  = 28,
  parameter int CS0_LG  = 26,
  parameter int CSX_LG  = 25,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_ack,
  input  logic              win_req,
  input  logic              win_we,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [1:0]        win_len,
  input  logic [31:0]       win_wdata,
  output logic [31:0]       win_rdata,
  output logic              win_ready,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [NUM_CS-1:0] user_mode, wr_en;
  logic              dec_hit;
  logic [CSW-1:0]    dec_idx;
  logic              sh_start, sh_busy, sh_done;
  logic [7:0]        sh_tx, sh_rx;
  acc_state_e        st;
  logic [1:0]        cnt, len, nxt;
  logic [31:0]       wd, acc, acc_nx;
  logic              is_wr;

  spi_ucp_regs #(.NUM_CS(NUM_CS), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ack(reg_ack), .cs_n(spi_cs_n),
    .user_mode(user_mode), .wr_en(wr_en));

  spi_ucp_decode #(.NUM_CS(NUM_CS), .WIN_AW(WIN_AW), .CS0_LG(CS0_LG),
                   .CSX_LG(CSX_LG)) u_dec (
    .addr(win_addr), .hit(dec_hit), .idx(dec_idx));

  spi_ucp_shifter #(.CLK_DIV(CLK_DIV)) u_sh (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx), .sck(spi_sck),
    .mosi(spi_mosi));

  assign nxt = cnt + 2'd1;

  always_comb begin
    acc_nx = acc;
    acc_nx[{cnt, 3'b000} +: 8] = sh_rx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ACC_IDLE; win_ready <= 1'b0; win_rdata <= '0; sh_start <= 1'b0;
      sh_tx <= '0; cnt <= '0; len <= '0; wd <= '0; acc <= '0; is_wr <= 1'b0;
    end else begin
      win_ready <= 1'b0;
      sh_start  <= 1'b0;
      case (st)
        ACC_IDLE: if (win_req && !win_ready) begin
          if (!dec_hit) begin
            win_rdata <= '0; win_ready <= 1'b1;
          end else if (!user_mode[dec_idx]) begin
            win_rdata <= win_we ? '0 : '1; win_ready <= 1'b1;
          end else if (win_we && !wr_en[dec_idx]) begin
            win_rdata <= '0; win_ready <= 1'b1;
          end else begin
            st <= ACC_XFER; cnt <= '0; len <= win_len; wd <= win_wdata;
            acc <= '0; is_wr <= win_we; sh_start <= 1'b1;
            sh_tx <= win_we ? win_wdata[7:0] : 8'h00;
          end
        end
        ACC_XFER: if (sh_done) begin
          if (cnt == len) begin
            win_rdata <= is_wr ? '0 : acc_nx;
            win_ready <= 1'b1;
            st <= ACC_IDLE;
          end else begin
            cnt <= nxt; acc <= acc_nx; sh_start <= 1'b1;
            sh_tx <= is_wr ? wd[{nxt, 3'b000} +: 8] : 8'h00;
          end
        end
        default: st <= ACC_IDLE;
      endcase
    end
  end

  // R11: ready is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    win_ready |=> !win_ready);
  // R8: no serial clock outside an accepted transfer
  a_r8_sck_only_xfer: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> (st == ACC_XFER));
  // R5: byte engine is idle whenever the access engine is idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ACC_IDLE && !sh_start) |-> !sh_busy);
endmodule

// File: tb/spi_flash_user_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_flash_user_ctrl_tb_top;
  localparam int NCS = 5;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_req = 0, reg_we = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_ack;
  logic win_req = 0, win_we = 0;
  logic [27:0] win_addr = '0;
  logic [1:0]  win_len = '0;
  logic [31:0] win_wdata = '0, win_rdata;
  logic win_ready, spi_sck, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_flash_user_ctrl #(.NUM_CS(NCS)) dut_i (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack), .win_req(win_req), .win_we(win_we),
    .win_addr(win_addr), .win_len(win_len), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .win_ready(win_ready), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // Loopback slave: first byte after selection is 0x3C, then each reply
  // is the previous received byte plus 0x11.
  logic sel;
  logic [7:0] s_tx = 8'h3C, s_rx = 8'h00;
  int s_bit = 0;
  bit s_skip = 0;
  logic [7:0]     log_b  [0:63];
  logic [NCS-1:0] log_cs [0:63];
  int log_n = 0;
  realtime last_rise = 0, sck_gap = 0;
  assign sel = ~&spi_cs_n;
  assign spi_miso = s_tx[7];

  always @(posedge sel) begin
    s_tx = 8'h3C; s_bit = 0; s_skip = 0;
  end
  always @(posedge spi_sck) begin
    sck_gap = $realtime - last_rise;
    last_rise = $realtime;
    if (sel) begin
      s_rx = {s_rx[6:0], spi_mosi};
      if (s_bit == 7) begin
        if (log_n < 64) begin
          log_b[log_n] = s_rx; log_cs[log_n] = spi_cs_n;
        end
        log_n = log_n + 1;
        s_tx = s_rx + 8'h11; s_bit = 0; s_skip = 1;
      end else s_bit = s_bit + 1;
    end
  end
  always @(negedge spi_sck) begin
    if (sel) begin
      if (s_skip) s_skip = 0;
      else s_tx = {s_tx[6:0], 1'b0};
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = 6'(a);
    @(negedge clk);
    reg_req = 0; d = reg_rdata;
  endtask

  // Window access; req may already be raised by the caller (pre = 1)
  task automatic win_acc(input bit we, input logic [27:0] a, input logic [1:0] l,
                         input logic [31:0] d, input bit pre, output logic [31:0] r);
    int cyc = 0;
    if (!pre) begin
      @(negedge clk);
      win_req = 1; win_we = we; win_addr = a; win_len = l; win_wdata = d;
    end
    do begin
      @(negedge clk);
      cyc++;
    end while (!win_ready && cyc < 2000);
    r = win_rdata;
    win_req = 0; win_we = 0;
    @(negedge clk);
    chk("R11 ready pulse width", {31'd0, win_ready}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 selects idle high", 32'(spi_cs_n), 32'h1F);
    reg_rd(4, v); chk("R1 ctrl0 reset", v, 32'h4);
    reg_rd(8, v); chk("R1 ctrl4 reset", v, 32'h4);
    reg_rd(0, v); chk("R1 cfg reset", v, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    reg_wr(1, 32'hCAFE0011); reg_rd(1, v); chk("R2 ext readback", v, 32'hCAFE0011);
    reg_wr(37, 32'h00001234); reg_rd(37, v); chk("R2 timing readback", v, 32'h00001234);
    reg_wr(9, 32'hFFFFFFFF); reg_rd(9, v); chk("R2 unimpl write ignored", v, 32'h0);
    reg_rd(2, v); chk("R2 unimpl reads zero", v, 32'h0);
    chk("R2 unimpl write no select", 32'(spi_cs_n), 32'h1F);
  endtask

  task automatic t_user_cs0();
    logic [31:0] v;
    int base;
    reg_wr(0, 32'h0001_0000);
    reg_wr(4, 32'h3);
    chk("R3 cs0 low after write", 32'(spi_cs_n), 32'h1E);
    base = log_n;
    win_acc(1, 28'h0000100, 2'd2, 32'h00A1B2C3, 0, v);
    chk("R6 byte count", 32'(log_n - base), 32'd3);
    chk("R6 byte0 lsb first", 32'(log_b[base]), 32'hC3);
    chk("R6 byte1", 32'(log_b[base+1]), 32'hB2);
    chk("R6 byte2", 32'(log_b[base+2]), 32'hA1);
    chk("R6 only cs0 selected", 32'(log_cs[base]), 32'h1E);
    base = log_n;
    win_acc(0, 28'h03FFFFC, 2'd3, 32'h0, 0, v);
    chk("R5 four byte load order", v, 32'h111111B2);
    chk("R5 zero driven", 32'(log_b[base+3]), 32'h00);
    chk("R10 sck period 40ns", 32'(int'(sck_gap)), 32'd40);
    reg_wr(4, 32'h7);
    chk("R3 cs0 high after write", 32'(spi_cs_n), 32'h1F);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    int base;
    reg_wr(0, 32'h0);
    reg_wr(5, 32'h3);
    base = log_n;
    win_acc(1, 28'h4000000, 2'd0, 32'h55, 0, v);
    chk("R7 store without permission dropped", 32'(log_n - base), 32'd0);
    win_acc(0, 28'h4000000, 2'd0, 32'h0, 0, v);
    chk("R7 slave untouched by dropped store", v, 32'h3C);
    reg_wr(0, 32'h0002_0000);
    base = log_n;
    win_acc(1, 28'h5FFFFFF, 2'd0, 32'h55, 0, v);
    chk("R7 permitted store", 32'(log_b[base]), 32'h55);
    chk("R9 cs1 region select", 32'(log_cs[base]), 32'h1D);
    reg_wr(5, 32'h7);
  endtask

  task automatic t_nonuser();
    logic [31:0] v;
    int base;
    reg_wr(0, 32'h0004_0000);
    reg_wr(6, 32'h6);
    reg_rd(6, v); chk("R4 mode field kept", v, 32'h6);
    base = log_n;
    win_acc(0, 28'h6000000, 2'd3, 32'h0, 0, v);
    chk("R8 non-user load all ones", v, 32'hFFFFFFFF);
    win_acc(1, 28'h6000000, 2'd1, 32'hBEEF, 0, v);
    chk("R8 no SPI traffic", 32'(log_n - base), 32'd0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    int base;
    reg_wr(8, 32'h3);
    base = log_n;
    win_acc(0, 28'hA000010, 2'd0, 32'h0, 0, v);
    chk("R9 cs4 region data", v, 32'h3C);
    chk("R9 cs4 selected", 32'(log_cs[base]), 32'h0F);
    reg_wr(8, 32'h7);
    base = log_n;
    win_acc(0, 28'hC000000, 2'd3, 32'h0, 0, v);
    chk("R9 beyond last region reads zero", v, 32'h0);
    chk("R9 beyond last region quiet", 32'(log_n - base), 32'd0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    int base;
    reg_wr(4, 32'h3);
    base = log_n;
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 6'd4; reg_wdata = 32'h0;
    win_req = 1; win_we = 0; win_addr = 28'h10; win_len = 2'd0;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    win_acc(0, 28'h10, 2'd0, 32'h0, 1, v);
    chk("R11 old mode used at acceptance", v, 32'h3C);
    chk("R11 exchange happened", 32'(log_n - base), 32'd1);
    win_acc(0, 28'h10, 2'd0, 32'h0, 0, v);
    chk("R4 new mode blocks load", v, 32'hFFFFFFFF);
    reg_wr(4, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_user_cs0();
    t_gate();
    t_nonuser();
    t_decode();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule